// File: doc/BRIEF.md
# Random Source Command and State Controller

This block is the control core of a true random number peripheral. Software reaches it through a plain register port with single-cycle writes and reads. A key-protected power register gates all other activity. A two-bit command field moves the controller between five states: idle (OFF), running (NORM), digital self-test (TDIG), analog self-test (TANA) and a locked error state (ERR). The entropy source, the self-test engines and the health monitor are outside the block. They are seen only as a sampled bit stream, pass flags and a failure strobe.

Each self-test lasts a fixed number of cycles. At its end the controller stores the pass result. After a digital test, and after a passing analog test, it returns to NORM without further commands. A failing analog test, or a health failure seen while running, locks the controller in ERR until an OFF command arrives. While running, the controller decimates the incoming bits and packs the kept bits into 32-bit words. The first word completed after any self-test carries a stale flag so that software can discard it. Three interrupt sources each have a raw bit, a mask bit and a write-one-to-clear bit, and they drive one interrupt line.

Top module: `rng_ctrl_top`

## Requirements
- R1: After reset the state code is OFF (0), power is off, and the interrupt raw bits, the mask bits and the irq output are all 0.
- R2: A write to address 0 changes the power bit to wdata[0] only when wdata[15:8] equals the key 0xA5. A write with any other key has no effect. While power is 0, the state is forced to OFF on the next clock.
- R3: A write to address 1 issues the command in wdata[1:0]: 0=OFF, 1=TDIG, 2=TANA, 3=NORM. The state code is read at address 7, bits [2:0]: OFF=0, NORM=1, TDIG=2, TANA=3, ERR=4. Bit 3 of that register is the power bit. Commands are ignored while power is 0. A NORM command given in OFF or NORM leaves the controller in NORM on the next clock and sets raw bit 0 (command done).
- R4: A TDIG command given in NORM runs for TEST_CYCLES clocks. At the end it stores dig_pass into address 2 bits [7:0], returns to NORM and sets raw bit 0.
- R5: A TANA command given in NORM runs for TEST_CYCLES clocks. At the end it stores ana_pass into address 2 bit 8 and sets raw bit 0. It then returns to NORM if ana_pass was 1, and enters ERR if ana_pass was 0.
- R6: In ERR every command other than OFF is ignored. OFF moves the controller to OFF and sets raw bit 0.
- R7: Write bits [6:4] hold the decimation code (rate minus 1). This code is loaded only by an accepted NORM command, which also restarts word assembly. The loaded code reads back at address 1, bits [6:4].
- R8: In NORM, a health_fail pulse moves the controller to ERR on the next clock and sets raw bit 2. It takes priority over any command written in the same cycle.
- R9: Address 7 bit 4 is 1 when the latest completed word is the first one after a finished self-test, and 0 for every later word.
- R10: In NORM, out of every rate valid input bits only the last one is kept. Each kept bit is shifted into the LSB of a 32-bit word. When 32 bits have been kept, the word appears at address 6 and raw bit 1 is set. A read of address 6 clears raw bit 1.
- R11: While a self-test runs, every command except OFF is ignored. OFF ends the test and gives state OFF on the next clock.
- R12: Raw bits are read at address 4, mask bits at address 3 (read/write), and a one written to address 5 clears the matching raw bit. irq is 1 exactly when some raw bit is set and its mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| ent_bit | input | 1 | Entropy bit |
| ent_valid | input | 1 | ent_bit is valid this cycle |
| dig_pass | input | 8 | Digital self-test pass flags |
| ana_pass | input | 1 | Analog self-test pass flag |
| health_fail | input | 1 | Health monitor failure strobe |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
A wrong state register shows up at the register port on the clock after the command, because the state code can be read directly. It also shows up later as a missing command-done bit, or as data words that never arrive. A fault in the test sequencer shifts the return to NORM away from exactly TEST_CYCLES clocks, and it can store the wrong result byte, so the bench reads both right after the window closes. A fault in word assembly changes the captured word, or the clock on which raw bit 1 rises, as soon as the first 32 bits are kept.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_NORM = 3'd1,
    ST_TDIG = 3'd2,
    ST_TANA = 3'd3,
    ST_ERR  = 3'd4
  } rng_state_e;

  typedef enum logic [1:0] {
    CMD_OFF  = 2'd0,
    CMD_TDIG = 2'd1,
    CMD_TANA = 2'd2,
    CMD_NORM = 2'd3
  } rng_cmd_e;

  localparam int unsigned IRQ_N    = 3;
  localparam int unsigned IRQ_DONE = 0;
  localparam int unsigned IRQ_CAP  = 1;
  localparam int unsigned IRQ_HLTH = 2;

  localparam logic [2:0] A_PWR  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_RES  = 3'd2;
  localparam logic [2:0] A_MASK = 3'd3;
  localparam logic [2:0] A_RAW  = 3'd4;
  localparam logic [2:0] A_CLR  = 3'd5;
  localparam logic [2:0] A_DATA = 3'd6;
  localparam logic [2:0] A_STAT = 3'd7;
endpackage

// File: rtl/rng_cmd_fsm.sv
module rng_cmd_fsm
  import rng_ctrl_pkg::*;
#(
  parameter int unsigned TEST_CYCLES = 16,
  parameter int unsigned DIG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd,
  input  logic [DIG_W-1:0] dig_pass,
  input  logic             ana_pass,
  input  logic             health_fail,
  output rng_state_e       state,
  output logic             done_evt,
  output logic             test_end,
  output logic             norm_acc,
  output logic             hlth_evt,
  output logic [DIG_W-1:0] dig_res,
  output logic             ana_res
);
  localparam int unsigned CNT_W = $clog2(TEST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TEST_CYCLES - 1);

  rng_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIG_W-1:0] dig_q, dig_d;
  logic             ana_q, ana_d;
  logic             cmd_off;

  assign cmd_off = cmd_valid && (cmd == CMD_OFF);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    dig_d    = dig_q;
    ana_d    = ana_q;
    done_evt = 1'b0;
    test_end = 1'b0;
    norm_acc = 1'b0;
    hlth_evt = 1'b0;
    if (!pwr_on) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          if (cmd_off) begin
            done_evt = 1'b1;
          end else if (cmd_valid && cmd == CMD_NORM) begin
            st_d     = ST_NORM;
            done_evt = 1'b1;
            norm_acc = 1'b1;
          end
        end
        ST_NORM: begin
          if (health_fail) begin
            st_d     = ST_ERR;
            hlth_evt = 1'b1;
          end else if (cmd_valid) begin
            unique case (cmd)
              CMD_OFF:  begin st_d = ST_OFF; done_evt = 1'b1; end
              CMD_NORM: begin done_evt = 1'b1; norm_acc = 1'b1; end
              CMD_TDIG: begin st_d = ST_TDIG; cnt_d = '0; end
              default:  begin st_d = ST_TANA; cnt_d = '0; end
            endcase
          end
        end
        ST_TDIG, ST_TANA: begin
          if (cmd_off) begin
            st_d     = ST_OFF;
            done_evt = 1'b1;
          end else if (cnt_q == CNT_LAST) begin
            done_evt = 1'b1;
            test_end = 1'b1;
            if (st_q == ST_TDIG) begin
              dig_d = dig_pass;
              st_d  = ST_NORM;
            end else begin
              ana_d = ana_pass;
              st_d  = ana_pass ? ST_NORM : ST_ERR;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (cmd_off) begin
            st_d     = ST_OFF;
            done_evt = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
      dig_q <= '0;
      ana_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      dig_q <= dig_d;
      ana_q <= ana_d;
    end
  end

  assign state   = st_q;
  assign dig_res = dig_q;
  assign ana_res = ana_q;

  AST_ERR_EXIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ERR) |=> (st_q == ST_ERR || st_q == ST_OFF)); // R6
  AST_DIG_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TDIG) |=> (st_q == ST_TDIG || st_q == ST_NORM || st_q == ST_OFF)); // R4
  AST_HEALTH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && st_q == ST_NORM && health_fail) |=> (st_q == ST_ERR)); // R8
  AST_TEST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_TDIG || st_q == ST_TANA) && cmd_off) |=> (st_q == ST_OFF)); // R11
  AST_NO_RUN_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on) |=> (st_q == ST_OFF)); // R2
endmodule

// File: rtl/rng_word_cap.sv
module rng_word_cap #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [DEC_W-1:0]  decim_m1,
  input  logic              ent_bit,
  input  logic              ent_valid,
  input  logic              mark_stale,
  output logic [WORD_W-1:0] word,
  output logic              word_evt,
  output logic              stale
);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic [DEC_W-1:0]  dcnt_q, dcnt_d;
  logic [BIT_W-1:0]  bcnt_q, bcnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              pend_q, pend_d;
  logic              stale_q, stale_d;

  always_comb begin
    dcnt_d   = dcnt_q;
    bcnt_d   = bcnt_q;
    sh_d     = sh_q;
    word_d   = word_q;
    word_evt = 1'b0;
    if (!run || restart) begin
      dcnt_d = '0;
      bcnt_d = '0;
    end else if (ent_valid) begin
      if (dcnt_q == decim_m1) begin
        dcnt_d = '0;
        sh_d   = {sh_q[WORD_W-2:0], ent_bit};
        if (bcnt_q == BIT_LAST) begin
          bcnt_d   = '0;
          word_d   = sh_d;
          word_evt = 1'b1;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end else begin
        dcnt_d = dcnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    pend_d  = pend_q;
    stale_d = stale_q;
    if (word_evt) begin
      stale_d = pend_q;
      pend_d  = 1'b0;
    end
    if (mark_stale) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      dcnt_q  <= dcnt_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
      word_q  <= word_d;
      pend_q  <= pend_d;
      stale_q <= stale_d;
    end
  end

  assign word  = word_q;
  assign stale = stale_q;

  AST_STALE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_evt && !mark_stale) |=> !pend_q); // R9
endmodule

// File: rtl/rng_irq_bank.sv
module rng_irq_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] raw_q, raw_d, mask_q, mask_d;

  always_comb begin
    raw_d  = (raw_q & ~clr) | set;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw  = raw_q;
  assign mask = mask_q;
  assign irq  = |(raw_q & mask_q);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((raw_q & $past(set)) == $past(set))); // R12
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set) != '0) |=> ((raw_q & $past(clr & ~set)) == '0)); // R12
endmodule

// File: rtl/rng_ctrl_top.sv
module rng_ctrl_top
  import rng_ctrl_pkg::*;
#(
  parameter int unsigned  TEST_CYCLES = 16,
  parameter int unsigned  WORD_W      = 32,
  parameter int unsigned  DEC_W       = 3,
  parameter int unsigned  DIG_W       = 8,
  parameter logic [7:0]   PWR_KEY     = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        ent_bit,
  input  logic        ent_valid,
  input  logic [7:0]  dig_pass,
  input  logic        ana_pass,
  input  logic        health_fail,
  output logic        irq
);
  localparam int unsigned DEC_LO = 4;
  localparam int unsigned DEC_HI = DEC_LO + DEC_W - 1;

  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic              pwr_q, pwr_d;
  logic [DEC_W-1:0]  decim_q, decim_d;
  rng_state_e        state;
  logic              done_evt, test_end, norm_acc, hlth_evt;
  logic [DIG_W-1:0]  dig_res;
  logic              ana_res;
  logic [WORD_W-1:0] word;
  logic              word_evt, stale;
  logic [IRQ_N-1:0]  irq_set, irq_clr, irq_raw, irq_mask;
  logic              cmd_valid, pwr_we, data_rd;
  logic              unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign pwr_we    = wr_en && (addr == A_PWR) && (wdata[15:8] == PWR_KEY);
  assign cmd_valid = wr_en && (addr == A_CTRL);
  assign data_rd   = rd_en && (addr == A_DATA);

  always_comb begin
    pwr_d   = pwr_we ? wdata[0] : pwr_q;
    decim_d = norm_acc ? wdata[DEC_HI:DEC_LO] : decim_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pwr_q   <= 1'b0;
      decim_q <= '0;
    end else begin
      pwr_q   <= pwr_d;
      decim_q <= decim_d;
    end
  end

  rng_cmd_fsm #(.TEST_CYCLES(TEST_CYCLES), .DIG_W(DIG_W)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .pwr_on(pwr_q), .cmd_valid(cmd_valid),
    .cmd(wdata[1:0]), .dig_pass(dig_pass[DIG_W-1:0]), .ana_pass(ana_pass),
    .health_fail(health_fail), .state(state), .done_evt(done_evt),
    .test_end(test_end), .norm_acc(norm_acc), .hlth_evt(hlth_evt),
    .dig_res(dig_res), .ana_res(ana_res)
  );

  rng_word_cap #(.WORD_W(WORD_W), .DEC_W(DEC_W)) u_cap (
    .clk(clk), .rst_n(rst_s_n), .run(state == ST_NORM), .restart(norm_acc),
    .decim_m1(decim_q), .ent_bit(ent_bit), .ent_valid(ent_valid),
    .mark_stale(test_end), .word(word), .word_evt(word_evt), .stale(stale)
  );

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_DONE] = done_evt;
    irq_set[IRQ_CAP]  = word_evt;
    irq_set[IRQ_HLTH] = hlth_evt;
    irq_clr           = (wr_en && addr == A_CLR) ? wdata[IRQ_N-1:0] : '0;
    irq_clr[IRQ_CAP]  = irq_clr[IRQ_CAP] | data_rd;
  end

  rng_irq_bank #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_s_n), .set(irq_set), .clr(irq_clr),
    .mask_we(wr_en && addr == A_MASK), .mask_wdata(wdata[IRQ_N-1:0]),
    .raw(irq_raw), .mask(irq_mask), .irq(irq)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_PWR:  rdata[0] = pwr_q;
      A_CTRL: rdata[DEC_HI:DEC_LO] = decim_q;
      A_RES:  rdata[DIG_W:0] = {ana_res, dig_res};
      A_MASK: rdata[IRQ_N-1:0] = irq_mask;
      A_RAW:  rdata[IRQ_N-1:0] = irq_raw;
      A_CLR:  rdata = '0;
      A_DATA: rdata[WORD_W-1:0] = word;
      default: rdata[4:0] = {stale, pwr_q, state};
    endcase
  end

  assign unused_wdata = ^{wdata[31:16], wdata[3:2], wdata[7], dig_pass};

  AST_CAP_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (data_rd && !word_evt) |=> !irq_raw[IRQ_CAP]); // R10
  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && addr == A_PWR && wdata[15:8] != PWR_KEY) |=> $stable(pwr_q)); // R2
endmodule

// File: tb/rng_ctrl_top_tb_top.sv
module rng_ctrl_top_tb_top;
  localparam int TC = 16;

  typedef struct {
    string       req;
    logic [31:0] msk;
    logic [31:0] val;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ent_bit = 1'b0, ent_valid = 1'b0;
  logic [7:0]  dig_pass = '0;
  logic        ana_pass = 1'b0;
  logic        health_fail = 1'b0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t        expq[$];
  logic [31:0] actq[$];

  always #10 clk = ~clk;

  rng_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ent_bit(ent_bit), .ent_valid(ent_valid),
    .dig_pass(dig_pass), .ana_pass(ana_pass), .health_fail(health_fail), .irq(irq)
  );

  function automatic logic src_bit(int i);
    return logic'(((i * 13) ^ (i >> 2) ^ (i >> 5)) & 1);
  endfunction

  function automatic logic [31:0] exp_word(int base, int rate);
    logic [31:0] w = '0;
    for (int k = 0; k < 32; k++) w = {w[30:0], src_bit(base + k * rate + rate - 1)};
    return w;
  endfunction

  task automatic expect_val(string req, logic [31:0] act, logic [31:0] msk, logic [31:0] val);
    expq.push_back('{req: req, msk: msk, val: val});
    actq.push_back(act);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic chk_reg(string req, logic [2:0] a, logic [31:0] msk, logic [31:0] val);
    logic [31:0] v;
    @(negedge clk); rd_en = 1'b1; addr = a;
    #2 v = rdata;
    @(negedge clk); rd_en = 1'b0;
    expect_val(req, v, msk, val);
  endtask

  task automatic chk_irq(string req, logic val);
    @(negedge clk);
    expect_val(req, {31'b0, irq}, 32'h1, {31'b0, val});
  endtask

  task automatic drive_bits(int n, int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ent_valid = 1'b1; ent_bit = src_bit(base + i);
    end
    @(negedge clk); ent_valid = 1'b0;
  endtask

  task automatic wait_test();
    repeat (TC + 1) @(negedge clk);
  endtask

  always @(posedge clk) begin
    while (expq.size() > 0 && actq.size() > 0) begin
      exp_t        e;
      logic [31:0] a;
      e = expq.pop_front();
      a = actq.pop_front();
      checks++;
      if ((a & e.msk) !== (e.val & e.msk)) begin
        errors++;
        $display("FAIL %s actual %h expected %h", e.req, a & e.msk, e.val & e.msk);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_reg("R1", 3'd7, 32'hF, 32'h0);
    chk_reg("R1", 3'd4, 32'h7, 32'h0);
    chk_reg("R1", 3'd3, 32'h7, 32'h0);
    chk_irq("R1", 1'b0);
    // R2 wrong key ignored
    wr(3'd0, 32'h0000_3C01);
    chk_reg("R2", 3'd0, 32'h1, 32'h0);
    // R3 command ignored while unpowered
    wr(3'd1, 32'h3);
    chk_reg("R3", 3'd7, 32'hF, 32'h0);
    wr(3'd0, 32'h0000_A501);
    chk_reg("R2", 3'd0, 32'h1, 32'h1);
    // R3 NORM with rate code 3
    wr(3'd1, 32'h33);
    chk_reg("R3", 3'd7, 32'hF, 32'h9);
    chk_reg("R3", 3'd4, 32'h1, 32'h1);
    wr(3'd5, 32'h7);
    chk_reg("R12", 3'd4, 32'h7, 32'h0);
    // R4 digital test; rate field must not load (R7); NORM during test ignored (R11)
    dig_pass = 8'hFF;
    wr(3'd1, 32'h71);
    chk_reg("R4", 3'd7, 32'hF, 32'hA);
    wr(3'd1, 32'h3);
    chk_reg("R11", 3'd7, 32'hF, 32'hA);
    wait_test();
    chk_reg("R4", 3'd7, 32'hF, 32'h9);
    chk_reg("R4", 3'd2, 32'hFF, 32'hFF);
    chk_reg("R4", 3'd4, 32'h1, 32'h1);
    chk_reg("R7", 3'd1, 32'h70, 32'h30);
    wr(3'd5, 32'h7);
    dig_pass = 8'h5A;
    wr(3'd1, 32'h1);
    wait_test();
    chk_reg("R4", 3'd2, 32'hFF, 32'h5A);
    // R5 analog pass
    ana_pass = 1'b1;
    wr(3'd1, 32'h2);
    wait_test();
    chk_reg("R5", 3'd7, 32'hF, 32'h9);
    chk_reg("R5", 3'd2, 32'h100, 32'h100);
    wr(3'd5, 32'h7);
    // R10 capture, rate 4
    wr(3'd3, 32'h2);
    drive_bits(128, 0);
    chk_reg("R10", 3'd4, 32'h2, 32'h2);
    chk_irq("R12", 1'b1);
    chk_reg("R9", 3'd7, 32'h10, 32'h10);
    chk_reg("R10", 3'd6, 32'hFFFF_FFFF, exp_word(0, 4));
    chk_reg("R10", 3'd4, 32'h2, 32'h0);
    chk_irq("R12", 1'b0);
    drive_bits(128, 128);
    chk_reg("R9", 3'd7, 32'h10, 32'h0);
    chk_reg("R10", 3'd6, 32'hFFFF_FFFF, exp_word(128, 4));
    // R7 new rate 2 via NORM command
    wr(3'd1, 32'h13);
    chk_reg("R7", 3'd1, 32'h70, 32'h10);
    drive_bits(64, 256);
    chk_reg("R7", 3'd6, 32'hFFFF_FFFF, exp_word(256, 2));
    drive_bits(40, 320);
    chk_reg("R10", 3'd4, 32'h2, 32'h0);
    // R8 health failure
    @(negedge clk); health_fail = 1'b1;
    @(negedge clk); health_fail = 1'b0;
    chk_reg("R8", 3'd7, 32'hF, 32'hC);
    chk_reg("R8", 3'd4, 32'h4, 32'h4);
    // R6 lock in error
    wr(3'd1, 32'h3);
    chk_reg("R6", 3'd7, 32'hF, 32'hC);
    wr(3'd5, 32'h7);
    wr(3'd1, 32'h0);
    chk_reg("R6", 3'd7, 32'hF, 32'h8);
    chk_reg("R6", 3'd4, 32'h1, 32'h1);
    // R5 analog fail
    wr(3'd1, 32'h3);
    ana_pass = 1'b0;
    wr(3'd1, 32'h2);
    wait_test();
    chk_reg("R5", 3'd7, 32'hF, 32'hC);
    chk_reg("R5", 3'd2, 32'h100, 32'h0);
    wr(3'd1, 32'h0);
    // R11 abort test with OFF
    wr(3'd1, 32'h3);
    wr(3'd1, 32'h1);
    wr(3'd1, 32'h0);
    chk_reg("R11", 3'd7, 32'hF, 32'h8);
    wait_test();
    chk_reg("R11", 3'd7, 32'hF, 32'h8);
    // R2 power off forces OFF
    wr(3'd1, 32'h3);
    chk_reg("R3", 3'd7, 32'hF, 32'h9);
    wr(3'd0, 32'h0000_A500);
    chk_reg("R2", 3'd7, 32'hF, 32'h0);
    chk_reg("R2", 3'd0, 32'h1, 32'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule